// File: doc/BRIEF.md
# Power-Supply Channel SPI Register Bank

This block is the serial-slave register bank for one programmable power-supply channel. A host sends fixed 24-bit frames. Each frame either writes a register or asks for one to be read back. The bank holds the channel's DAC input word, a gain word and an offset word. It keeps a calibrated DAC code derived from those three and drives it on `dac_code`. It also holds two read-only words: a status word and a latched alarm word.

Readback is deferred. A read request only captures the addressed value into the transmit shift register. The host collects that value on `sdo` while it sends its next frame, whatever that frame is.

After `rst_n` is released, an internal sequencer keeps the interface closed for `POR_CYC` clock cycles and holds `busy_n` low. Frames are accepted only once `busy_n` has risen. The synchronous `reset_req` input restores all registers to their defaults, but only after that point.

Top module: `psu_spi_regbank`

## Requirements
- R1: A frame is a run of SCLK rising edges while `sync_n` is low, shifted in MSB first. Bit 23 selects read (1) or write (0), bits 22:16 hold the address and bits 15:0 hold the data. The frame takes effect when `sync_n` returns high. A frame with any bit count other than 24 is discarded.
- R2: A write frame updates the input word at address 0x08, the gain word at 0x28 and the offset word at 0x30.
- R3: A read request captures the addressed value. During the following frame, that value appears on `sdo` over the first 16 SCLK periods, MSB first, and each bit is valid before its SCLK rising edge. During any frame that follows a frame other than a read request, `sdo` shows zeros.
- R4: Writes to 0x43 and 0x44 have no effect.
- R5: Reading 0x43 returns the comparator inputs in bits 5:4 and the latched alarm flags in bits 3:0. All other bits are zero.
- R6: Reading 0x44 returns the latched alarm flags in bits 3:0. That read clears every flag and drives all `alarm_pin` outputs low.
- R7: A high bit on `alm_evt` sets the matching flag, which stays set until it is cleared. `alarm_pin` follows the flags.
- R8: `dac_code` equals x1*(m+1)/65536 + c - 32768, saturated to 0..65535, and follows register changes within one cycle. Writes to address 0x10 are ignored. Reads of 0x10 or of any unmapped address return zero.
- R9: While `rst_n` is low and for `POR_CYC` cycles after its release, `busy_n` is low. During that time frames are ignored and alarm events are not latched. Once `busy_n` goes high it stays high.
- R10: The defaults are input 0x8000, gain 0xFFFF and offset 0x8000, which gives `dac_code` 0x8000.
- R11: `reset_req` has no effect while `busy_n` is low and does not lengthen the power-on sequence. At any other time it restores the defaults and clears the alarm flags.
- R12: `sdo_en` is low whenever `sync_n` is high and high while it is low.
- R13: A frame with bit 23 set and a nonzero data field is discarded. It performs no write, and the next frame's `sdo` shows zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| reset_req | input | 1 | Synchronous restore-defaults request, active high |
| sclk | input | 1 | Serial clock |
| sync_n | input | 1 | Frame select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for the `sdo` pad driver |
| busy_n | output | 1 | Goes high when the power-on sequence is complete |
| cmp_in | input | 2 | Live comparator results |
| alm_evt | input | 4 | Alarm event pulses |
| alarm_pin | output | 4 | Latched alarm outputs |
| dac_code | output | 16 | Calibrated DAC code |

## Verification
The bench reads each register back while a different frame is being sent. A design that answered during the request frame itself would return the previous capture, and every deferred value would come out shifted by one row. It sends frames of 23 and 25 bits, a read request with nonzero data, writes to the read-only and write-only addresses, and a read of an unmapped address. A decoder that accepted any of these would change `dac_code`, corrupt a register or leak stale data onto `sdo`. It also checks that the alarm word holds its value across the frame that clears it and reads zero afterwards. Finally, it fires `reset_req` and an alarm event during the power-on window, which catches a sequencer that restarts its count or a latch that is enabled too early.

// File: rtl/psu_spi_regbank.sv
module psu_spi_regbank #(
  parameter int          POR_CYC = 400,
  parameter logic [15:0] X1_DEF  = 16'h8000,
  parameter logic [15:0] M_DEF   = 16'hFFFF,
  parameter logic [15:0] C_DEF   = 16'h8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reset_req,
  input  logic        sclk,
  input  logic        sync_n,
  input  logic        sdi,
  output logic        sdo,
  output logic        sdo_en,
  output logic        busy_n,
  input  logic [1:0]  cmp_in,
  input  logic [3:0]  alm_evt,
  output logic [3:0]  alarm_pin,
  output logic [15:0] dac_code
);
  localparam int CW = $clog2(POR_CYC + 1);
  localparam logic [4:0] FRAME_BITS = 5'd24;
  localparam logic [6:0] A_X1 = 7'h08, A_X2 = 7'h10, A_M = 7'h28,
                         A_C = 7'h30, A_STAT = 7'h43, A_ALM = 7'h44;

  function automatic logic [15:0] cal(input logic [15:0] x, input logic [15:0] g,
                                      input logic [15:0] o);
    logic [32:0] p;
    logic signed [18:0] s;
    p = 33'(x) * (33'(g) + 33'd1);
    s = $signed({2'b00, p[32:16]}) + $signed({3'b000, o}) - 19'sd32768;
    if (s < 0) return 16'h0000;
    else if (s > 19'sd65535) return 16'hFFFF;
    else return s[15:0];
  endfunction

  localparam logic [15:0] X2_DEF = cal(X1_DEF, M_DEF, C_DEF);

  logic [CW-1:0] por_cnt;
  logic [2:0]    sclk_q, sync_q;
  logic [1:0]    sdi_q;
  logic [23:0]   rx_sh;
  logic [15:0]   tx_sh, x1, m, c, x2, rdata;
  logic [4:0]    nbit;
  logic [3:0]    flags;

  assign busy_n = (por_cnt == CW'(POR_CYC));

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire sync_rise = sync_q[1] & ~sync_q[2];
  wire sync_fall = ~sync_q[1] & sync_q[2];
  wire sync_lo   = ~sync_q[1];
  wire shift_en  = sclk_rise & sync_lo;

  wire [6:0]  f_addr   = rx_sh[22:16];
  wire [15:0] f_data   = rx_sh[15:0];
  wire        frame_ok = busy_n & sync_rise & (nbit == FRAME_BITS);
  wire        do_wr    = frame_ok & ~rx_sh[23];
  wire        do_rd    = frame_ok & rx_sh[23] & (f_data == 16'h0000);
  wire        clr_alm  = do_rd & (f_addr == A_ALM);
  wire        soft_rst = reset_req & busy_n;

  always_comb begin
    case (f_addr)
      A_X1:    rdata = x1;
      A_M:     rdata = m;
      A_C:     rdata = c;
      A_STAT:  rdata = {10'b0, cmp_in, flags};
      A_ALM:   rdata = {12'b0, flags};
      default: rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       por_cnt <= '0;
    else if (!busy_n) por_cnt <= por_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= 3'b000;
      sync_q <= 3'b111;
      sdi_q  <= 2'b00;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      sync_q <= {sync_q[1:0], sync_n};
      sdi_q  <= {sdi_q[0], sdi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sh <= '0;  tx_sh <= '0;  nbit <= '0;  flags <= '0;
      x1 <= X1_DEF; m <= M_DEF; c <= C_DEF; x2 <= X2_DEF;
    end else if (soft_rst) begin
      rx_sh <= '0;  tx_sh <= '0;  nbit <= '0;  flags <= '0;
      x1 <= X1_DEF; m <= M_DEF; c <= C_DEF; x2 <= X2_DEF;
    end else begin
      if (sync_fall)                           nbit <= '0;
      else if (shift_en && nbit != 5'd31)      nbit <= nbit + 5'd1;
      if (shift_en) begin
        rx_sh <= {rx_sh[22:0], sdi_q[1]};
        tx_sh <= {tx_sh[14:0], 1'b0};
      end else if (sync_rise) begin
        tx_sh <= do_rd ? rdata : 16'h0000;
      end
      if (do_wr) begin
        case (f_addr)
          A_X1:    x1 <= f_data;
          A_M:     m  <= f_data;
          A_C:     c  <= f_data;
          default: ;
        endcase
      end
      flags <= (clr_alm ? 4'b0000 : flags) | (busy_n ? alm_evt : 4'b0000);
      x2    <= cal(x1, m, c);
    end

  assign sdo       = tx_sh[15];
  assign sdo_en    = ~sync_n;
  assign alarm_pin = flags;
  assign dac_code  = x2;
endmodule

// File: rtl/psu_spi_regbank_chk.sv
module psu_spi_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_n,
  input logic       soft_rst,
  input logic       clr_alm,
  input logic [3:0] alm_evt,
  input logic [3:0] alarm_pin
);
  AST_BUSY_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |=> busy_n); // R9
  AST_NO_ALARM_IN_POR: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> alarm_pin == 4'b0000); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_alm && !soft_rst) |=> ((alarm_pin & $past(alarm_pin)) == $past(alarm_pin))); // R7
  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && !soft_rst) |=> ((alarm_pin & $past(alm_evt)) == $past(alm_evt))); // R7
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_alm && alm_evt == 4'b0000) |=> alarm_pin == 4'b0000); // R6
endmodule

bind psu_spi_regbank psu_spi_regbank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .soft_rst(soft_rst),
  .clr_alm(clr_alm), .alm_evt(alm_evt), .alarm_pin(alarm_pin)
);

// File: tb/psu_spi_regbank_tb_top.sv
module psu_spi_regbank_tb_top;
  localparam int POR = 400;
  localparam int NV  = 13;
  // {frame, sdo word expected during this frame, dac_code expected after it}
  localparam logic [55:0] VEC [NV] = '{
    {24'h081234, 16'h0000, 16'h1234},
    {24'h880000, 16'h0000, 16'h1234},
    {24'h287FFF, 16'h1234, 16'h091A},
    {24'hA80000, 16'h0000, 16'h091A},
    {24'hB00000, 16'h7FFF, 16'h091A},
    {24'h435555, 16'h8000, 16'h091A},
    {24'hC30000, 16'h0000, 16'h091A},
    {24'h900000, 16'h0020, 16'h091A},
    {24'h10ABCD, 16'h0000, 16'h091A},
    {24'hD50000, 16'h0000, 16'h091A},
    {24'h880001, 16'h0000, 16'h091A},
    {24'h880000, 16'h0000, 16'h091A},
    {24'h309000, 16'h1234, 16'h191A}
  };

  logic clk = 0, rst_n = 0, reset_req = 0, sclk = 0, sync_n = 1, sdi = 0;
  logic [1:0] cmp_in = 2'b10;
  logic [3:0] alm_evt = 4'b0000;
  logic sdo, sdo_en, busy_n;
  logic [3:0] alarm_pin;
  logic [15:0] dac_code, rx;
  int checks = 0, fails = 0, busy_cnt = 0;

  always #2 clk = ~clk;

  psu_spi_regbank #(.POR_CYC(POR)) dut_i (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .sclk(sclk), .sync_n(sync_n),
    .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en), .busy_n(busy_n), .cmp_in(cmp_in),
    .alm_evt(alm_evt), .alarm_pin(alarm_pin), .dac_code(dac_code));

  always @(posedge clk)
    if (!rst_n) busy_cnt <= 0;
    else if (!busy_n) busy_cnt <= busy_cnt + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] word, input int nbits, output logic [15:0] got);
    got = 16'h0000;
    sync_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = word[nbits-1-i];
      repeat (4) @(negedge clk);
      if (i < 16) got[15-i] = sdo;
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
    end
    repeat (4) @(negedge clk);
    sync_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_alarm(input logic [3:0] v);
    alm_evt = v;
    @(negedge clk);
    alm_evt = 4'b0000;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 busy low in reset", busy_n, 0);
    check("R12 sdo_en idle", sdo_en, 0);
    check("R10 default dac_code", dac_code, 16'h8000);
    check("R7 pins clear at reset", alarm_pin, 0);
    rst_n = 1;
    reset_req = 1; @(negedge clk); reset_req = 0;   // R11 during power-on
    pulse_alarm(4'b0011);                            // R9 ignored
    xfer(32'h084444, 24, rx);                        // R9 ignored frame
    while (!busy_n) @(negedge clk);
    check("R9 R11 power-on length", busy_cnt, POR);
    check("R9 no alarm latched in power-on", alarm_pin, 0);

    xfer(32'h880000, 24, rx);
    xfer(32'hA80000, 24, rx);
    check("R10 R9 x1 default after ignored frame", rx, 16'h8000);
    xfer(32'hB00000, 24, rx);
    check("R10 m default", rx, 16'hFFFF);
    xfer(32'h430000, 24, rx);
    check("R10 c default", rx, 16'h8000);

    for (int k = 0; k < NV; k++) begin
      xfer({8'h00, VEC[k][55:32]}, 24, rx);
      check($sformatf("R2 R3 R4 R8 R13 row %0d sdo", k), rx, VEC[k][31:16]);
      check($sformatf("R8 row %0d dac_code", k), dac_code, VEC[k][15:0]);
    end

    xfer(32'h0008ABCD, 25, rx);                      // R1 long frame
    xfer(32'h0008ABCD, 23, rx);                      // R1 short frame
    check("R1 bad length no write", dac_code, 16'h191A);
    xfer(32'h880000, 24, rx);
    xfer(32'h430000, 24, rx);
    check("R1 x1 kept", rx, 16'h1234);

    sync_n = 0; repeat (4) @(negedge clk);
    check("R12 sdo_en in frame", sdo_en, 1);
    sync_n = 1; repeat (6) @(negedge clk);
    check("R12 sdo_en after frame", sdo_en, 0);

    pulse_alarm(4'b0101);
    check("R7 alarm latched", alarm_pin, 4'b0101);
    repeat (20) @(negedge clk);
    check("R7 alarm held", alarm_pin, 4'b0101);
    xfer(32'hC30000, 24, rx);
    xfer(32'hC40000, 24, rx);
    check("R5 status word", rx, 16'h0025);
    check("R6 pins cleared by read", alarm_pin, 4'b0000);
    xfer(32'h430000, 24, rx);
    check("R6 alarm word before clear", rx, 16'h0005);
    xfer(32'hC40000, 24, rx);
    xfer(32'h430000, 24, rx);
    check("R6 alarm word after clear", rx, 16'h0000);

    xfer(32'h085555, 24, rx);
    pulse_alarm(4'b1000);
    check("R7 single flag", alarm_pin, 4'b1000);
    reset_req = 1; @(negedge clk); reset_req = 0;
    repeat (2) @(negedge clk);
    check("R11 flags cleared", alarm_pin, 0);
    check("R11 dac default", dac_code, 16'h8000);
    check("R11 busy stays high", busy_n, 1);
    xfer(32'h880000, 24, rx);
    xfer(32'h430000, 24, rx);
    check("R11 x1 restored", rx, 16'h8000);

    finish_run();
  end
endmodule